// File: doc/BRIEF.md
# Slot-Timed Load-Modulation Response Transmitter

This block sends a tag's reply to a reader by load modulation. It drives a subcarrier-enable line: the line is high for a 1 and low for a 0. Each bit fills one fixed slot of 21 ticks.

The block has no baud clock of its own. Every slot sits at an absolute tick value, derived from a reference timestamp that marks the end of the reader's last frame. A free-running tick count is compared against that schedule.

There are two reply kinds:
- A data reply carries up to 12 bits. Each bit is whitened by XOR with a keystream bit supplied from outside.
- An acknowledge is a single plain 1. It is sent after a much longer gap.

The block also steps the external keystream generator. During the idle gap it issues as many steps as there are whole bit periods in the gap, minus one. After that it issues one step per bit sent.

When the reply ends, the block hands back the updated timestamp. The next receive phase is timed from that value.

Top module: `lm_slot_tx`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `mod_en_o` is 0. `done_o` is 0 after reset.
- R2: For a data reply (`ack_i`=0), the first slot begins 70 ticks after `ref_ts_i`. `mod_en_o` stays 0 before that point.
- R3: Data bits go out from bit 0 of `frame_i` upward, one per 21-tick slot. The level of slot i is `frame_i[i]` XOR the `ks_bit_i` value present once the preceding keystream steps have taken effect.
- R4: For a data reply of n bits, `ks_step_o` pulses exactly 2 times before the first slot and once after each slot, so 2+n pulses in total.
- R5: For an acknowledge (`ack_i`=1), a single slot holding 1 begins 758 ticks after `ref_ts_i`, and the keystream is ignored. `ks_step_o` pulses 35 times before the slot and once after it.
- R6: `mod_en_o` keeps its level for a whole slot and across a boundary between two slots of equal value. It returns to 0 within a few cycles after the last slot ends.
- R7: At the end of every reply, `done_o` is a single-cycle pulse. At that moment `ts_o` becomes `ref_ts_i` + wait + 21×(bits sent), and it holds that value until the next reply ends.
- R8: `busy_o` is high from the cycle after an accepted start until the reply ends. A `start_i` seen while busy is ignored and changes neither the bits, the step count nor `ts_o`.
- R9: A data `len_i` above 12 sends 12 bits. A `len_i` of 0 sends one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a reply; sampled only while idle |
| ack_i | input | 1 | Reply kind: 1 = acknowledge, 0 = data |
| frame_i | input | 12 | Data bits, bit 0 sent first |
| len_i | input | 4 | Number of data bits |
| ref_ts_i | input | 16 | End-of-reader-frame timestamp in ticks |
| now_i | input | 16 | Free-running tick count |
| ks_bit_i | input | 1 | Current keystream bit |
| mod_en_o | output | 1 | Subcarrier modulation enable |
| done_o | output | 1 | One-cycle pulse at end of reply |
| ks_step_o | output | 1 | Advance the keystream by one step |
| busy_o | output | 1 | Reply in progress |
| ts_o | output | 16 | Timestamp at end of last reply |

## Verification
Slot boundaries are absolute tick values. `mod_en_o` settles two to three clock cycles after `now_i` reaches a boundary, because the due compare, a state register and the output register lie on the path.

The bench therefore samples the line 10 ticks into every slot, 5 ticks before the first slot, and 6 ticks after the last slot ends. These points are far from any transition.

The keystream step count, the done pulse count and `ts_o` are read at that final point, after all pulses have been registered. The expected keystream bit for slot i is computed in the bench by stepping its own copy of the generator (pre-advance + i) times.

// File: rtl/tmx_pkg.sv
package tmx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_WAIT,
        ST_SLOT,
        ST_STEP
    } tx_state_e;
endpackage

// File: rtl/tmx_due.sv
module tmx_due #(
    parameter int TS_W = 16
) (
    input  logic [TS_W-1:0] now_i,
    input  logic [TS_W-1:0] deadline_i,
    output logic            due_o
);
    logic [TS_W-1:0] diff;

    // Wrap-safe: the deadline is due once now is not behind it
    assign diff  = now_i - deadline_i;
    assign due_o = ~diff[TS_W-1];
endmodule

// File: rtl/tmx_bitsel.sv
module tmx_bitsel #(
    parameter int DATA_W = 12,
    parameter int IDX_W  = 4
) (
    input  logic [DATA_W-1:0] frame_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              ack_i,
    input  logic              ks_i,
    output logic              bit_o
);
    always_comb begin
        if (ack_i) begin
            bit_o = 1'b1;
        end else begin
            bit_o = frame_i[idx_i] ^ ks_i;
        end
    end
endmodule

// File: rtl/lm_slot_tx.sv
module lm_slot_tx
    import tmx_pkg::*;
#(
    parameter int TS_W      = 16,
    parameter int DATA_W    = 12,
    parameter int LEN_W     = 4,
    parameter int BIT_TICKS = 21,
    parameter int DATA_WAIT = 70,
    parameter int ACK_WAIT  = 758
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ack_i,
    input  logic [DATA_W-1:0] frame_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [TS_W-1:0]   ref_ts_i,
    input  logic [TS_W-1:0]   now_i,
    input  logic              ks_bit_i,
    output logic              mod_en_o,
    output logic              done_o,
    output logic              ks_step_o,
    output logic              busy_o,
    output logic [TS_W-1:0]   ts_o
);
    localparam int DATA_ADV = DATA_WAIT / BIT_TICKS - 1;
    localparam int ACK_ADV  = ACK_WAIT / BIT_TICKS - 1;
    localparam int CNT_W    = $clog2(ACK_ADV + 2);
    localparam int IDX_W    = $clog2(DATA_W);

    typedef struct packed {
        tx_state_e         st;
        logic              ack;
        logic [DATA_W-1:0] frame;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last_idx;
        logic [CNT_W-1:0]  cnt;
        logic [TS_W-1:0]   dl;
        logic              fin;
        logic              mod;
        logic              done;
        logic [TS_W-1:0]   ts;
    } regs_t;

    regs_t q, d;
    logic  due;
    logic  sel_bit;
    logic [LEN_W-1:0] len_c;

    tmx_due #(.TS_W(TS_W)) u_due (
        .now_i      (now_i),
        .deadline_i (q.dl),
        .due_o      (due)
    );

    tmx_bitsel #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_sel (
        .frame_i (q.frame),
        .idx_i   (q.idx),
        .ack_i   (q.ack),
        .ks_i    (ks_bit_i),
        .bit_o   (sel_bit)
    );

    always_comb begin
        // Clamp the requested length into 1..DATA_W
        if (len_i == '0) begin
            len_c = LEN_W'(1);
        end else if (int'(len_i) > DATA_W) begin
            len_c = LEN_W'(DATA_W);
        end else begin
            len_c = len_i;
        end

        d      = q;
        d.done = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.ack   = ack_i;
                    d.frame = frame_i;
                    d.idx   = '0;
                    d.fin   = 1'b0;
                    d.mod   = 1'b0;
                    if (ack_i) begin
                        d.last_idx = '0;
                        d.dl       = ref_ts_i + TS_W'(ACK_WAIT);
                        d.cnt      = CNT_W'(ACK_ADV);
                        d.st       = (ACK_ADV > 0) ? ST_PREP : ST_WAIT;
                    end else begin
                        d.last_idx = IDX_W'(len_c - LEN_W'(1));
                        d.dl       = ref_ts_i + TS_W'(DATA_WAIT);
                        d.cnt      = CNT_W'(DATA_ADV);
                        d.st       = (DATA_ADV > 0) ? ST_PREP : ST_WAIT;
                    end
                end
            end
            ST_PREP: begin
                // One keystream step per cycle while here
                d.cnt = q.cnt - CNT_W'(1);
                if (q.cnt == CNT_W'(1)) begin
                    d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (due) begin
                    d.mod = sel_bit;
                    d.dl  = q.dl + TS_W'(BIT_TICKS);
                    d.st  = ST_SLOT;
                end
            end
            ST_SLOT: begin
                if (due) begin
                    d.st = ST_STEP;
                    if (q.idx == q.last_idx) begin
                        d.mod = 1'b0;
                        d.fin = 1'b1;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                    end
                end
            end
            ST_STEP: begin
                if (q.fin) begin
                    d.done = 1'b1;
                    d.ts   = q.dl;
                    d.st   = ST_IDLE;
                end else begin
                    d.st = ST_WAIT;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign mod_en_o  = q.mod;
    assign done_o    = q.done;
    assign ts_o      = q.ts;
    assign busy_o    = (q.st != ST_IDLE);
    assign ks_step_o = (q.st == ST_PREP) || (q.st == ST_STEP);

    // R1: no modulation while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mod_en_o);

    // R5: an acknowledge slot is always modulated
    p_ack_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SLOT && q.ack) |-> mod_en_o);

    // R6: level is held for the whole slot
    p_slot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SLOT && $past(q.st == ST_SLOT)) |-> $stable(mod_en_o));

    // R7: done is a single-cycle pulse
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: timestamp only changes together with done
    p_ts_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(ts_o));

    // R8: start while busy leaves the captured frame untouched
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(q.frame));
endmodule

// File: tb/tb_lm_slot_tx.sv
`timescale 1ns/1ps
module tb_lm_slot_tx;
    localparam logic [6:0] SEED = 7'h5B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        ack_i = 1'b0;
    logic [11:0] frame_i = '0;
    logic [3:0]  len_i = '0;
    logic [15:0] ref_ts_i = '0;
    logic [15:0] tick_now = '0;
    logic        ks_bit;
    logic        mod_en, done, ks_step, busy;
    logic [15:0] ts;

    logic [6:0]  ks_state = SEED;
    logic        clear = 1'b0;
    int          steps = 0;
    int          dones = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 0;

    always #10 clk = ~clk;

    always @(posedge clk) tick_now <= tick_now + 16'd1;

    assign ks_bit = ks_state[0];

    always @(posedge clk) begin
        if (clear) begin
            ks_state <= SEED;
            steps    <= 0;
            dones    <= 0;
        end else begin
            if (rst_n && ks_step) begin
                ks_state <= {ks_state[5:0], ks_state[6] ^ ks_state[5]};
                steps    <= steps + 1;
            end
            if (rst_n && done) dones <= dones + 1;
        end
    end

    lm_slot_tx dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_i(ack_i),
        .frame_i(frame_i), .len_i(len_i), .ref_ts_i(ref_ts_i), .now_i(tick_now),
        .ks_bit_i(ks_bit), .mod_en_o(mod_en), .done_o(done), .ks_step_o(ks_step),
        .busy_o(busy), .ts_o(ts)
    );

    function automatic logic ks_after(int k);
        logic [6:0] s = SEED;
        for (int j = 0; j < k; j++) s = {s[5:0], s[6] ^ s[5]};
        return s[0];
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(logic [15:0] t);
        while (tick_now != t) @(negedge clk);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(mod_en == 1'b0, "R1 mod after reset", mod_en, 0);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Sends one reply and checks every slot, the step count, done and ts
    task automatic send(bit ack, logic [11:0] frame, logic [3:0] len, bit poke, string tag);
        int n, wt, pre;
        logic [15:0] rf;
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        n   = ack ? 1 : ((len == 0) ? 1 : ((len > 12) ? 12 : int'(len)));
        wt  = ack ? 758 : 70;
        pre = wt / 21 - 1;
        rf  = tick_now + 16'd5;
        start_i = 1'b1; ack_i = ack; frame_i = frame; len_i = len; ref_ts_i = rf;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy == 1'b1, {tag, " R8 busy after start"}, busy, 1);
        if (poke) begin
            wait_tick(rf + 16'd30);
            start_i = 1'b1; ack_i = ~ack; frame_i = ~frame; len_i = 4'd3; ref_ts_i = rf + 16'd7;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait_tick(rf + 16'(wt - 5));
        chk(mod_en == 1'b0, {tag, ack ? " R5 quiet before ack" : " R2 quiet before first slot"}, mod_en, 0);
        for (int i = 0; i < n; i++) begin
            logic e;
            wait_tick(rf + 16'(wt + 21 * i + 10));
            e = ack ? 1'b1 : (frame[i] ^ ks_after(pre + i));
            chk(mod_en == e, {tag, ack ? " R5 ack slot" : " R3 data slot"}, mod_en, e);
            if (i == 0) chk(busy == 1'b1, {tag, " R8 busy during reply"}, busy, 1);
        end
        wait_tick(rf + 16'(wt + 21 * n + 6));
        chk(mod_en == 1'b0, {tag, " R6 low after last slot"}, mod_en, 0);
        chk(steps == pre + n, {tag, ack ? " R5 step count" : " R4 step count"}, steps, pre + n);
        chk(dones == 1, {tag, " R7 done pulses"}, dones, 1);
        chk(ts == rf + 16'(wt + 21 * n), {tag, " R7 ts"}, ts, int'(rf + 16'(wt + 21 * n)));
        chk(busy == 1'b0, {tag, " R8 idle at end"}, busy, 0);
        chk(mod_en == 1'b0, {tag, " R1 idle low"}, mod_en, 0);
    endtask

    initial begin
        test_reset();
        send(1'b0, 12'hA5C, 4'd12, 1'b0, "full data");
        send(1'b0, 12'h00D, 4'd6,  1'b0, "six bits");
        send(1'b0, 12'hFFF, 4'd4,  1'b0, "R6 ones held");
        send(1'b1, 12'h000, 4'd0,  1'b0, "ack");
        send(1'b0, 12'h3C6, 4'd9,  1'b1, "R8 start while busy");
        send(1'b0, 12'h9B1, 4'd15, 1'b0, "R9 clamp high");
        send(1'b0, 12'h001, 4'd0,  1'b0, "R9 zero len");
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule